// File: doc/BRIEF.md
# Branch Target Buffer with Selectable Combining Policy

This block predicts the next fetch address for a pipelined front end. A small fully associative table is searched with the current fetch address in the same cycle. Each entry stores a branch address, a 2-bit saturating direction counter and the most recent taken target. A separate direct-mapped history table, indexed by low fetch-address bits, holds a 2-bit counter and a last taken target for every slot. It serves as the explicit predictor when the associative search misses.

A static 2-bit policy input decides how a hit or miss is combined with the explicit history. In the implicit policy, a hit always redirects. In the hit-first policy, a hit redirects and a miss defers to the history table. In the gated policy, a miss goes sequential and a hit redirects only when that entry's own counter predicts taken. Resolved branches come back through an update port. The port refreshes a matching entry, allocates a new one round-robin when a taken branch misses, and always trains the history table.

Top module: `btb_pred`

## Requirements
- R1: While reset is low, and on the first cycle after it, no lookup hits. Every history counter is weakly not-taken (value 1), so every policy outputs fetch address + 4.
- R2: With policy 0, a hit outputs the stored target and a miss outputs fetch address + 4.
- R3: With policy 1, a hit outputs the stored target whatever its counter holds. A miss reads history slot fetch_addr[5:2] and outputs that slot's target when its counter is 2 or 3, and fetch address + 4 otherwise.
- R4: With policy 2, a miss outputs fetch address + 4 even when the history predicts taken. A hit outputs the stored target when the entry counter is 2 or 3, and fetch address + 4 when it is 0 or 1.
- R5: A resolved taken branch that misses allocates an entry with counter 2 and its target. A resolved not-taken branch that misses allocates nothing.
- R6: On a hit, the entry counter increments on taken and decrements on not-taken, saturating at 3 and 0.
- R7: A taken resolution that hits overwrites the stored target with the resolved target.
- R8: Allocations fill the 8 entries in round-robin order. Once all are full, each new allocation evicts the entry that has been resident longest.
- R9: A lookup and an update to the same address in one cycle: the lookup sees the table contents from before the update.
- R10: Policy value 3 behaves as policy 0.
- R11: hit_o is high exactly when a valid entry holds the fetch address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| policy_i | input | 2 | Combining policy: 0 implicit, 1 hit-first, 2 gated, 3 as 0 |
| fetch_addr_i | input | 32 | Current fetch address |
| next_addr_o | output | 32 | Predicted next fetch address (combinational) |
| hit_o | output | 1 | Fetch address found in the buffer |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |
| upd_target_i | input | 32 | Resolved target address |

## Verification
The bench drives a counter to both saturation limits and back. A design that wraps instead would flip a confident prediction after one further update. It aliases a missing address onto a trained history slot, which separates policy 1 from policy 2: swapped or merged policies redirect where they should fall through. It issues a lookup and an update to the same address in one cycle, where a write-through design would hit early. It fills all eight entries and then allocates twice more. Wrong replacement order would evict a recent branch and keep the oldest one.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef enum logic [1:0] {
    POL_IMPLICIT = 2'd0,
    POL_HIT_TGT  = 2'd1,
    POL_GATED    = 2'd2,
    POL_SPARE    = 2'd3
  } policy_e;

  localparam logic [1:0] CTR_WEAK_NT = 2'd1;
  localparam logic [1:0] CTR_WEAK_T  = 2'd2;

  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    logic [1:0] n;
    n = c;
    if (taken && c != 2'd3) n = c + 2'd1;
    else if (!taken && c != 2'd0) n = c - 2'd1;
    return n;
  endfunction

  function automatic logic ctr_says_taken(input logic [1:0] c);
    return c[1];
  endfunction

endpackage

// File: rtl/btb_rr.sv
module btb_rr #(
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [IDX_W-1:0] ptr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ptr_o <= '0;
    else if (adv_i) ptr_o <= (ptr_o == IDX_W'(ENTRIES - 1)) ? '0 : ptr_o + 1'b1;
  end
endmodule

// File: rtl/btb_cam.sv
module btb_cam
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int ENTRIES = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] look_addr_i,
  output logic [ENTRIES-1:0] look_match_o,
  output logic              look_hit_o,
  output logic [ADDR_W-1:0] look_tgt_o,
  output logic [1:0]        look_ctr_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i,
  input  logic [IDX_W-1:0]  alloc_idx_i,
  output logic              alloc_o
);
  logic [ENTRIES-1:0] vld_q;
  logic [ADDR_W-1:0]  pc_q  [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [1:0]         ctr_q [ENTRIES];
  logic [ENTRIES-1:0] upd_match;
  logic               upd_hit;

  assign upd_hit = |upd_match;
  assign alloc_o = upd_valid_i && !upd_hit && upd_taken_i;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic wr_hit, wr_new;
    assign look_match_o[g] = vld_q[g] && (pc_q[g] == look_addr_i);
    assign upd_match[g]    = vld_q[g] && (pc_q[g] == upd_pc_i);
    assign wr_hit = upd_valid_i && upd_match[g];
    assign wr_new = alloc_o && (alloc_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        pc_q[g]  <= '0;
        tgt_q[g] <= '0;
        ctr_q[g] <= '0;
      end else if (wr_hit) begin
        ctr_q[g] <= ctr_step(ctr_q[g], upd_taken_i);
        if (upd_taken_i) tgt_q[g] <= upd_target_i;
      end else if (wr_new) begin
        vld_q[g] <= 1'b1;
        pc_q[g]  <= upd_pc_i;
        tgt_q[g] <= upd_target_i;
        ctr_q[g] <= CTR_WEAK_T;
      end
    end
  end

  // at most one match, so an OR-reduction acts as the mux
  always_comb begin
    look_tgt_o = '0;
    look_ctr_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (look_match_o[i]) begin
        look_tgt_o = look_tgt_o | tgt_q[i];
        look_ctr_o = look_ctr_o | ctr_q[i];
      end
    end
  end
  assign look_hit_o = |look_match_o;
endmodule

// File: rtl/btb_hist.sv
module btb_hist
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int DEPTH       = 16,
  parameter int INSTR_BYTES = 4,
  localparam int HIDX_W     = $clog2(DEPTH),
  localparam int OFF_W      = $clog2(INSTR_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rd_taken_o,
  output logic [ADDR_W-1:0] rd_tgt_o,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_taken_i,
  input  logic [ADDR_W-1:0] wr_tgt_i
);
  logic [1:0]        ctr_q [DEPTH];
  logic [ADDR_W-1:0] tgt_q [DEPTH];
  logic [HIDX_W-1:0] rd_idx, wr_idx;

  assign rd_idx = rd_addr_i[OFF_W +: HIDX_W];
  assign wr_idx = wr_addr_i[OFF_W +: HIDX_W];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctr_q[g] <= CTR_WEAK_NT;
        tgt_q[g] <= '0;
      end else if (wr_valid_i && wr_idx == HIDX_W'(g)) begin
        ctr_q[g] <= ctr_step(ctr_q[g], wr_taken_i);
        if (wr_taken_i) tgt_q[g] <= wr_tgt_i;
      end
    end
  end

  assign rd_taken_o = ctr_says_taken(ctr_q[rd_idx]);
  assign rd_tgt_o   = tgt_q[rd_idx];
endmodule

// File: rtl/btb_next.sv
module btb_next
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int INSTR_BYTES = 4
) (
  input  policy_e           policy_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  input  logic              hit_i,
  input  logic [ADDR_W-1:0] hit_tgt_i,
  input  logic [1:0]        hit_ctr_i,
  input  logic              hist_taken_i,
  input  logic [ADDR_W-1:0] hist_tgt_i,
  output logic [ADDR_W-1:0] next_addr_o
);
  logic [ADDR_W-1:0] seq_addr;
  assign seq_addr = fetch_addr_i + ADDR_W'(INSTR_BYTES);

  always_comb begin
    next_addr_o = seq_addr;
    unique case (policy_i)
      POL_HIT_TGT: begin
        if (hit_i)             next_addr_o = hit_tgt_i;
        else if (hist_taken_i) next_addr_o = hist_tgt_i;
      end
      POL_GATED: begin
        if (hit_i && ctr_says_taken(hit_ctr_i)) next_addr_o = hit_tgt_i;
      end
      default: begin
        if (hit_i) next_addr_o = hit_tgt_i;
      end
    endcase
  end
endmodule

// File: rtl/btb_pred.sv
module btb_pred
  import btb_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 8,
  parameter int HIST_DEPTH  = 16,
  parameter int INSTR_BYTES = 4,
  localparam int IDX_W      = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        policy_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic              hit_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  logic [ENTRIES-1:0] look_match;
  logic [ADDR_W-1:0]  hit_tgt, hist_tgt;
  logic [1:0]         hit_ctr;
  logic               hist_taken, alloc;
  logic [IDX_W-1:0]   rr_ptr;

  btb_cam #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_cam (
    .clk_i, .rst_ni,
    .look_addr_i  (fetch_addr_i),
    .look_match_o (look_match),
    .look_hit_o   (hit_o),
    .look_tgt_o   (hit_tgt),
    .look_ctr_o   (hit_ctr),
    .upd_valid_i, .upd_pc_i, .upd_taken_i, .upd_target_i,
    .alloc_idx_i  (rr_ptr),
    .alloc_o      (alloc)
  );

  btb_rr #(.ENTRIES(ENTRIES)) u_rr (
    .clk_i, .rst_ni, .adv_i(alloc), .ptr_o(rr_ptr)
  );

  btb_hist #(.ADDR_W(ADDR_W), .DEPTH(HIST_DEPTH), .INSTR_BYTES(INSTR_BYTES)) u_hist (
    .clk_i, .rst_ni,
    .rd_addr_i  (fetch_addr_i),
    .rd_taken_o (hist_taken),
    .rd_tgt_o   (hist_tgt),
    .wr_valid_i (upd_valid_i),
    .wr_addr_i  (upd_pc_i),
    .wr_taken_i (upd_taken_i),
    .wr_tgt_i   (upd_target_i)
  );

  btb_next #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_next (
    .policy_i     (policy_e'(policy_i)),
    .fetch_addr_i,
    .hit_i        (hit_o),
    .hit_tgt_i    (hit_tgt),
    .hit_ctr_i    (hit_ctr),
    .hist_taken_i (hist_taken),
    .hist_tgt_i   (hist_tgt),
    .next_addr_o
  );
endmodule

// File: rtl/btb_pred_chk.sv
module btb_pred_chk #(
  parameter int ADDR_W      = 32,
  parameter int ENTRIES     = 8,
  parameter int INSTR_BYTES = 4
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [1:0]         policy_i,
  input logic [ADDR_W-1:0]  fetch_addr_i,
  input logic [ADDR_W-1:0]  next_addr_o,
  input logic               hit_o,
  input logic               upd_valid_i,
  input logic [ADDR_W-1:0]  upd_pc_i,
  input logic               upd_taken_i,
  input logic [ENTRIES-1:0] match_i,
  input logic [ADDR_W-1:0]  hit_tgt_i
);
  logic              first_q, last_tk_q;
  logic [ADDR_W-1:0] last_pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      first_q   <= 1'b1;
      last_tk_q <= 1'b0;
      last_pc_q <= '0;
    end else begin
      first_q   <= 1'b0;
      last_tk_q <= upd_valid_i && upd_taken_i;
      last_pc_q <= upd_pc_i;
    end
  end

  p_cold_miss_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_q |-> !hit_o);

  p_pol0_miss_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd0 && !hit_o) |-> next_addr_o == fetch_addr_i + ADDR_W'(INSTR_BYTES));

  p_pol0_hit_tgt_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd0 && hit_o) |-> next_addr_o == hit_tgt_i);

  p_pol1_hit_tgt_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd1 && hit_o) |-> next_addr_o == hit_tgt_i);

  p_pol2_miss_seq_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'd2 && !hit_o) |-> next_addr_o == fetch_addr_i + ADDR_W'(INSTR_BYTES));

  p_taken_resident_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_tk_q && fetch_addr_i == last_pc_q) |-> hit_o);

  p_unique_match_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(match_i));

  p_hit_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o == (match_i != '0));
endmodule

bind btb_pred btb_pred_chk #(
  .ADDR_W(ADDR_W), .ENTRIES(ENTRIES), .INSTR_BYTES(INSTR_BYTES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .policy_i(policy_i),
  .fetch_addr_i(fetch_addr_i), .next_addr_o(next_addr_o), .hit_o(hit_o),
  .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
  .match_i(look_match), .hit_tgt_i(hit_tgt)
);

// File: tb/btb_pred_tb.sv
`timescale 1ns/1ps
module btb_pred_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  policy = '0;
  logic [31:0] fetch = '0;
  logic [31:0] next_addr;
  logic        hit;
  logic        upd_v = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_tk = 1'b0;
  logic [31:0] upd_tgt = '0;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  btb_pred u_dut (
    .clk_i(clk), .rst_ni(rst_n), .policy_i(policy), .fetch_addr_i(fetch),
    .next_addr_o(next_addr), .hit_o(hit), .upd_valid_i(upd_v), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_tk), .upd_target_i(upd_tgt)
  );

  typedef struct packed {
    logic        upd;
    logic [31:0] pc;
    logic        tk;
    logic [31:0] tgt;
    logic [1:0]  pol;
    logic [31:0] fa;
    logic [31:0] exp_next;
    logic        exp_hit;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd0, 32'h100, 32'h104, 1'b0, 8'd1},  // R1 empty
    '{1'b1, 32'h100, 1'b1, 32'h400, 2'd0, 32'h100, 32'h104, 1'b0, 8'd9},  // R9 pre-update view
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd0, 32'h100, 32'h400, 1'b1, 8'd5},  // R5 allocated
    '{1'b1, 32'h100, 1'b0, 32'h0,   2'd2, 32'h100, 32'h400, 1'b1, 8'd4},  // R4 ctr 2
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd2, 32'h100, 32'h104, 1'b1, 8'd4},  // R4 ctr 1
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd1, 32'h100, 32'h400, 1'b1, 8'd3},  // R3 hit ignores ctr
    '{1'b1, 32'h100, 1'b0, 32'h0,   2'd0, 32'h100, 32'h400, 1'b1, 8'd2},  // R2 hit
    '{1'b1, 32'h100, 1'b0, 32'h0,   2'd2, 32'h100, 32'h104, 1'b1, 8'd6},  // R6 ctr 0
    '{1'b1, 32'h100, 1'b1, 32'h400, 2'd2, 32'h100, 32'h104, 1'b1, 8'd6},  // R6 floor held
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd2, 32'h100, 32'h104, 1'b1, 8'd6},  // R6 ctr 1
    '{1'b1, 32'h100, 1'b1, 32'h500, 2'd2, 32'h100, 32'h104, 1'b1, 8'd6},  // R6
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd0, 32'h100, 32'h500, 1'b1, 8'd7},  // R7 new target
    '{1'b1, 32'h100, 1'b1, 32'h500, 2'd2, 32'h100, 32'h500, 1'b1, 8'd6},  // R6 ctr 2
    '{1'b1, 32'h100, 1'b1, 32'h500, 2'd2, 32'h100, 32'h500, 1'b1, 8'd6},  // R6 ctr 3
    '{1'b1, 32'h100, 1'b0, 32'h0,   2'd2, 32'h100, 32'h500, 1'b1, 8'd6},  // R6 ceiling held
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd2, 32'h100, 32'h500, 1'b1, 8'd6},  // R6 ctr 2
    '{1'b1, 32'h204, 1'b0, 32'h0,   2'd0, 32'h204, 32'h208, 1'b0, 8'd5},  // R5 nt miss
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd0, 32'h204, 32'h208, 1'b0, 8'd5},  // R5 not allocated
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd1, 32'h140, 32'h500, 1'b0, 8'd3},  // R3 miss, hist slot 0 taken
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd2, 32'h140, 32'h144, 1'b0, 8'd4},  // R4 miss seq
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd0, 32'h140, 32'h144, 1'b0, 8'd2},  // R2 miss seq
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd3, 32'h100, 32'h500, 1'b1, 8'd10}, // R10 hit
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd3, 32'h140, 32'h144, 1'b0, 8'd10}, // R10 miss
    '{1'b0, 32'h0,   1'b0, 32'h0,   2'd1, 32'h204, 32'h208, 1'b0, 8'd3}   // R3 hist not taken
  };

  task automatic check(input logic [31:0] en, input logic eh, input string tag);
    total++;
    if (next_addr !== en || hit !== eh) begin
      bad++;
      $display("FAIL %s fetch=%h next=%h hit=%b expected next=%h hit=%b",
               tag, fetch, next_addr, hit, en, eh);
    end
  endtask

  // drive at negedge, check before the next posedge commits the update
  task automatic step(input logic u, input logic [31:0] pc, input logic tk,
                      input logic [31:0] tg, input logic [1:0] pl, input logic [31:0] fa,
                      input logic [31:0] en, input logic eh, input string tag);
    @(negedge clk);
    upd_v = u; upd_pc = pc; upd_tk = tk; upd_tgt = tg; policy = pl; fetch = fa;
    #1 check(en, eh, tag);
  endtask

  initial begin
    #150000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    fetch = 32'h100; policy = 2'd1;
    #5 check(32'h104, 1'b0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].upd, VECS[i].pc, VECS[i].tk, VECS[i].tgt, VECS[i].pol, VECS[i].fa,
           VECS[i].exp_next, VECS[i].exp_hit, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end

    // R8: slot 0 holds 0x100; fill slots 1..7
    for (int k = 1; k < 8; k++) begin
      step(1'b1, 32'h2000 + 32'(k) * 32'h10, 1'b1, 32'h3000 + 32'(k),
           2'd0, 32'h204, 32'h208, 1'b0, "R8 fill");
    end
    step(1'b1, 32'h9000, 1'b1, 32'h9900, 2'd0, 32'h100, 32'h500, 1'b1, "R9 victim still visible");
    step(1'b0, 0, 1'b0, 0, 2'd0, 32'h100, 32'h104, 1'b0, "R8 oldest evicted");
    step(1'b0, 0, 1'b0, 0, 2'd0, 32'h2010, 32'h3001, 1'b1, "R8 second kept");
    step(1'b0, 0, 1'b0, 0, 2'd0, 32'h2070, 32'h3007, 1'b1, "R8 last fill kept");
    step(1'b1, 32'hA000, 1'b1, 32'hA800, 2'd0, 32'h9000, 32'h9900, 1'b1, "R11 new entry hit");
    step(1'b0, 0, 1'b0, 0, 2'd0, 32'h2010, 32'h2014, 1'b0, "R8 next oldest evicted");
    step(1'b0, 0, 1'b0, 0, 2'd0, 32'h2020, 32'h3002, 1'b1, "R8 third kept");
    step(1'b0, 0, 1'b0, 0, 2'd0, 32'hA000, 32'hA800, 1'b1, "R11 hit flag");

    // R1: reset clears entries and history
    @(negedge clk); rst_n = 1'b0; policy = 2'd1; fetch = 32'h9000;
    #1 check(32'h9004, 1'b0, "R1 during reset");
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 0, 1'b0, 0, 2'd1, 32'h140, 32'h144, 1'b0, "R1 history weak not-taken");
    step(1'b0, 0, 1'b0, 0, 2'd0, 32'hA000, 32'hA004, 1'b0, "R1 entries cleared");

    @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule